// File: doc/BRIEF.md
# Microsecond Tick Generator

This block derives a one-cycle tick every microsecond from a 20 MHz or 40 MHz reference clock. A free-running counter climbs by one on every reference cycle. When it reaches a terminal count it returns to zero, and the tick fires on that wrap. The tick period is therefore the terminal count plus one reference cycles.

The terminal count comes from a 6-bit setting. A setting of zero selects automatic mode. In that mode the terminal count is 39 when a crystal-frequency strap reports a 40 MHz reference, and 19 when it reports 20 MHz. Any nonzero setting is used directly as the terminal count. The strap is captured while reset is held and then stays fixed.

A second, slower square wave is produced for a low-frequency reference pin. It toggles once every `SLOW_HALF` ticks.

Top module: `usec_tick_gen`

## Requirements
- R1: While reset is asserted, the tick and the slow output are both 0, the counter is cleared and the setting is expected at zero (automatic mode). After release, the first tick appears exactly terminal-count-plus-one cycles later.
- R2: With a nonzero setting N, ticks repeat every N+1 reference cycles. This holds down to N=1 (every 2 cycles) and up to N=63 (every 64 cycles).
- R3: With a setting of 0 and the strap captured as 1 (40 MHz), ticks repeat every 40 cycles.
- R4: With a setting of 0 and the strap captured as 0 (20 MHz), ticks repeat every 20 cycles.
- R5: The strap is sampled while reset is asserted and held after release. Changing the strap after release has no effect on the tick period.
- R6: The tick is high for exactly one reference cycle per period and is never high in two consecutive cycles.
- R7: If the setting drops below the current counter value, the counter wraps to zero on the next clock and a tick is emitted in that cycle. The counter never runs past the terminal count.
- R8: The slow output starts low and toggles only in a cycle in which the tick is high. It toggles once every `SLOW_HALF` ticks (default 16), so with setting 3 its level holds for 64 cycles between toggles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, 20 or 40 MHz |
| rst | input | 1 | Synchronous active-high reset; the strap is sampled while it is high |
| div_sel | input | CNT_W (6) | Terminal count setting; 0 selects automatic mode |
| strap_40m | input | 1 | Crystal indication: 1 for 40 MHz, 0 for 20 MHz |
| tick_o | output | 1 | One-cycle pulse per period |
| slow_o | output | 1 | Slow square wave, toggled every SLOW_HALF ticks |

## Verification
The embedded properties check the following on every cycle:
- the tick never lasts two cycles;
- a tick always coincides with a cleared counter;
- a counter that finds itself above the terminal count is cleared on the next clock;
- the captured strap stays constant outside reset;
- the slow output changes only alongside a tick.

The actual period lengths can only be shown by the bench's scenarios. These cover:
- the manual setting values, including the smallest and largest;
- both automatic frequencies;
- the irrelevance of the strap after reset;
- the exact cycle of the forced wrap when the setting is lowered;
- the slow output's half-period.

// File: rtl/usec_tick_gen.sv
module usec_tick_gen #(
  parameter int CNT_W      = 6,
  parameter int AUTO_HI_TC = 39,
  parameter int AUTO_LO_TC = 19,
  parameter int SLOW_HALF  = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] div_sel,
  input  logic             strap_40m,
  output logic             tick_o,
  output logic             slow_o
);

  localparam logic [CNT_W-1:0] TC_HI = CNT_W'(AUTO_HI_TC);
  localparam logic [CNT_W-1:0] TC_LO = CNT_W'(AUTO_LO_TC);

  logic             strap_q;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] term;
  logic             wrap;

  assign term = (div_sel == '0) ? (strap_q ? TC_HI : TC_LO) : div_sel;
  assign wrap = (cnt >= term);

  always_ff @(posedge clk) begin
    if (rst) begin
      strap_q <= strap_40m;
      cnt     <= '0;
      tick_o  <= 1'b0;
    end else begin
      cnt     <= wrap ? '0 : cnt + CNT_W'(1);
      tick_o  <= wrap;
    end
  end

  generate
    if (SLOW_HALF > 0) begin : g_slow
      localparam int SW = (SLOW_HALF > 1) ? $clog2(SLOW_HALF) : 1;
      localparam logic [SW-1:0] SLAST = SW'(SLOW_HALF - 1);
      logic [SW-1:0] scnt;
      always_ff @(posedge clk) begin
        if (rst) begin
          scnt   <= '0;
          slow_o <= 1'b0;
        end else if (wrap) begin
          if (scnt == SLAST) begin
            scnt   <= '0;
            slow_o <= ~slow_o;
          end else begin
            scnt   <= scnt + SW'(1);
          end
        end
      end
    end else begin : g_noslow
      assign slow_o = 1'b0;
    end
  endgenerate

  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> !tick_o);

  assert_tick_at_zero_R2: assert property (@(posedge clk) disable iff (rst)
    tick_o |-> (cnt == '0));

  assert_no_overrun_R7: assert property (@(posedge clk) disable iff (rst)
    (cnt > term) |=> (cnt == '0));

  assert_strap_held_R5: assert property (@(posedge clk) disable iff (rst)
    !rst |=> $stable(strap_q));

  assert_slow_with_tick_R8: assert property (@(posedge clk) disable iff (rst)
    !$stable(slow_o) |-> tick_o);

endmodule

// File: tb/tb_usec_tick_gen.sv
module tb_usec_tick_gen;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] div_sel = '0;
  logic       strap_40m = 1'b1;
  logic       tick_o, slow_o;

  int errors = 0;
  int checks = 0;
  int exp_q[$];
  string tag_q[$];
  bit discard = 1'b0;
  bit finished = 1'b0;

  usec_tick_gen dut (
    .clk(clk), .rst(rst), .div_sel(div_sel), .strap_40m(strap_40m),
    .tick_o(tick_o), .slow_o(slow_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic expect_periods(input int p, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(p);
      tag_q.push_back(tag);
    end
  endtask

  task automatic drain();
    while (exp_q.size() > 0) @(negedge clk);
  endtask

  task automatic set_div(input int v);
    @(negedge clk);
    discard = 1'b1;
    div_sel = 6'(v);
  endtask

  task automatic do_reset(input bit strap_v);
    @(negedge clk);
    rst = 1'b1;
    div_sel = '0;
    strap_40m = strap_v;
    repeat (3) @(negedge clk);
    chk(tick_o == 1'b0, "R1 tick in reset", int'(tick_o), 0);
    chk(slow_o == 1'b0, "R1 slow in reset", int'(slow_o), 0);
    rst = 1'b0;
  endtask

  // monitor: pops expected periods and compares against observed ones
  int  since = 0;
  bit  prev_tick = 1'b0;
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (rst) begin
      since = 0;
      prev_tick = 1'b0;
      discard = 1'b0;
    end else begin
      since++;
      if (tick_o) begin
        chk(!prev_tick, "R6 consecutive tick", 1, 0);
        if (discard) discard = 1'b0;
        else if (exp_q.size() > 0) begin
          int e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(since == e, t, since, e);
        end
        since = 0;
      end
      prev_tick = tick_o;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1 / R3: reset with 40 MHz strap, automatic mode
    do_reset(1'b1);
    expect_periods(40, 1, "R1 first tick after reset");
    expect_periods(40, 3, "R3 auto 40MHz period");
    drain();

    // R2: manual settings
    set_div(9);
    expect_periods(10, 3, "R2 manual 9");
    drain();
    set_div(1);
    expect_periods(2, 4, "R2 manual 1");
    drain();
    set_div(63);
    expect_periods(64, 2, "R2 manual 63");
    drain();

    // R7: lower the setting below the running count
    set_div(39);
    expect_periods(40, 2, "R2 manual 39");
    drain();
    while (tick_o !== 1'b1) @(negedge clk);
    repeat (20) @(negedge clk);
    discard = 1'b1;
    div_sel = 6'd5;
    @(posedge clk);
    #(CLK_PERIOD/4);
    chk(tick_o == 1'b1, "R7 forced wrap tick", int'(tick_o), 1);
    expect_periods(6, 3, "R7 period after lowering");
    drain();

    // R8: slow output half period with setting 3
    set_div(3);
    begin
      logic b;
      int n;
      b = slow_o;
      while (slow_o == b) @(negedge clk);
      b = slow_o;
      n = 0;
      while (slow_o == b) begin
        @(negedge clk);
        n++;
      end
      chk(n == 64, "R8 slow half period", n, 64);
    end

    // R3: back to automatic mode
    set_div(0);
    expect_periods(40, 2, "R3 auto after manual");
    drain();

    // R5 / R4: reset with 20 MHz strap, then flip the strap
    do_reset(1'b0);
    strap_40m = 1'b1;
    expect_periods(20, 1, "R5 strap change ignored");
    expect_periods(20, 3, "R4 auto 20MHz period");
    drain();

    repeat (5) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule